// File: doc/BRIEF.md
# Serial Word Port

This block is a synchronous slave front end that gives a host access to a small word-organised RAM over four serial pins: a select line, a serial clock, a data input and a data output with a separate output-enable. All pins are sampled in the system clock domain. The serial clock may run at any rate well below the system clock, and it may stop at any point.

After select goes high the block ignores zero bits until it sees a one, which starts an instruction byte. The byte carries a word address and an opcode. A write instruction is followed by a data word. A read instruction makes the block return the addressed word. The five control opcodes produce a one-cycle pulse on their own output, which goes to a separate nonvolatile control block. A busy input from that block blocks every instruction. A write-permit input decides whether a received data word reaches the RAM.

Top module: `serial_word_port`

## Requirements
- R1: While select is high, zero bits on the data input are skipped. The first one bit sampled on a rising serial clock becomes the first bit of the instruction byte.
- R2: The instruction is 8 bits, shifted most significant bit first on rising serial clock edges. Bit 7 is the start one, bits 6..3 are the word address, and bits 2..0 are the opcode: 000 write-disable, 001 store, 010 auto-store enable, 011 write, 100 write-enable, 101 recall, 11x read.
- R3: Each of the five control opcodes produces exactly one single-cycle pulse on its own command output (`cmd_wrds_o`, `cmd_sto_o`, `cmd_enas_o`, `cmd_wren_o`, `cmd_rcl_o`). No other command output pulses.
- R4: For a read, instruction bit 0 is ignored. Data bit 0 appears after the falling edge of serial clock 8. Bits 1 to 15 follow, one on each rising edge from clock 9 to clock 23. The output enable drops after rising edge 24.
- R5: The output enable is low, and the data output is 0, at all times other than during read data output. This includes reset and every instruction phase.
- R6: For a write, data bits 0 to 15 are taken on rising edges 9 to 24, bit 0 first. When select falls, they are committed as one RAM write pulse, but only if at least one data bit was received. A write never overlaps read output.
- R7: When select falls before all 16 data bits have arrived, the bits that did arrive are written and the other bits of the word keep their stored value.
- R8: When select stays high past clock 24 in a write, clock 25 and later clocks overwrite data bits from bit 0 upward, wrapping modulo 16.
- R9: When write-permit is low in the cycle that the commit would be issued, no RAM write pulse is issued.
- R10: When busy is high as the eighth instruction bit is taken, the instruction is ignored: no command pulse, no RAM write and no read output.
- R11: When select goes low at any point, framing resets. The next access must begin with a new start bit and is decoded correctly.
- R12: When the serial clock stops, all state is held and the data output does not change until clocking resumes.
- R13: The read word is captured from the RAM once, at decode. A change to that RAM word during the read does not change the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Serial select, active high, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| din_i | input | 1 | Serial data input, asynchronous |
| dout_o | output | 1 | Serial data output |
| dout_en_o | output | 1 | Output enable for the external tri-state driver |
| busy_i | input | 1 | Nonvolatile control block is busy; instructions are ignored |
| wr_permit_i | input | 1 | RAM writes are permitted |
| ram_addr_o | output | 4 | RAM word address |
| ram_wdata_o | output | 16 | RAM write data |
| ram_rdata_i | input | 16 | RAM read data (combinational at ram_addr_o) |
| ram_we_o | output | 1 | RAM write strobe, one cycle |
| cmd_wrds_o | output | 1 | Write-disable command pulse |
| cmd_wren_o | output | 1 | Write-enable command pulse |
| cmd_sto_o | output | 1 | Store command pulse |
| cmd_rcl_o | output | 1 | Recall command pulse |
| cmd_enas_o | output | 1 | Auto-store enable command pulse |

## Verification
Every one of the sixteen addresses is read and written with address-dependent words. The number of leading zeros and the ignored read bit vary from frame to frame, which shows whether framing locks onto the start bit alone and whether bit order and address decode are right. The control opcodes are swept with both all-zero and all-one don't-care fields, which separates opcode decode from address bits. Writes of 0, 1, 5, 12, 16 and 20 bits tell a partial commit apart from a full commit and from a wrap-around overwrite. Runs with a stopped clock, busy held high, permit held low, and a RAM word changed during a read each show a behaviour that the plain sweeps cannot tell apart.

// File: rtl/sshift_pkg.sv
package sshift_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic [2:0] {
    OP_WRDS  = 3'b000,
    OP_STO   = 3'b001,
    OP_ENAS  = 3'b010,
    OP_WRITE = 3'b011,
    OP_WREN  = 3'b100,
    OP_RCL   = 3'b101,
    OP_READA = 3'b110,
    OP_READB = 3'b111
  } op_e;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_INSTR,
    FR_WDATA,
    FR_RWAIT,
    FR_RDATA,
    FR_DONE
  } frame_e;

  typedef struct packed {
    logic wrds;
    logic sto;
    logic enas;
    logic wren;
    logic rcl;
  } cmd_t;
endpackage

// File: rtl/sshift_sync.sv
module sshift_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/sshift_frame.sv
module sshift_frame
  import sshift_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel_s,
  input  logic                      sck_rise,
  input  logic                      sck_fall,
  input  logic                      din_s,
  input  logic                      busy_i,
  input  logic                      wr_permit_i,
  output logic [ADDR_W-1:0]         addr_o,
  output logic                      load_o,
  output logic                      wbit_o,
  output logic [$clog2(DATA_W)-1:0] bidx_o,
  output logic                      drive_o,
  output logic                      we_o,
  output cmd_t                      cmd_o
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int IBITS  = ADDR_W + 3;
  localparam int ICNT_W = $clog2(IBITS);
  localparam int BIDX_W = $clog2(DATA_W);
  localparam logic [ICNT_W-1:0] ICNT_LAST = ICNT_W'(IBITS - 1);
  localparam logic [BIDX_W-1:0] BIDX_LAST = BIDX_W'(DATA_W - 1);

  frame_e              state_q, state_d;
  logic [IBITS-2:0]    ir_q, ir_d;
  logic [ICNT_W-1:0]   icnt_q, icnt_d;
  logic [BIDX_W-1:0]   bidx_q, bidx_d;
  logic                got_q, got_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                load_q, load_d;
  logic                drive_q, drive_d;
  logic                we_q, we_d;
  cmd_t                cmd_q, cmd_d;
  logic                wbit;
  logic [IBITS-1:0]    full;

  assign full = {ir_q, din_s};

  always_comb begin
    state_d = state_q;
    ir_d    = ir_q;
    icnt_d  = icnt_q;
    bidx_d  = bidx_q;
    got_d   = got_q;
    addr_d  = addr_q;
    load_d  = 1'b0;
    drive_d = drive_q;
    we_d    = 1'b0;
    cmd_d   = '0;
    wbit    = 1'b0;
    if (!sel_s) begin
      state_d = FR_IDLE;
      drive_d = 1'b0;
      icnt_d  = '0;
      got_d   = 1'b0;
      we_d    = (state_q == FR_WDATA) && got_q && wr_permit_i;
    end else begin
      case (state_q)
        FR_IDLE: begin
          if (sck_rise && din_s) begin
            state_d = FR_INSTR;
            icnt_d  = '0;
          end
        end
        FR_INSTR: begin
          if (sck_rise) begin
            ir_d   = full[IBITS-2:0];
            icnt_d = icnt_q + 1'b1;
            if (icnt_q == ICNT_LAST) begin
              if (busy_i) begin
                state_d = FR_DONE;
              end else begin
                case (op_e'(full[2:0]))
                  OP_READA, OP_READB: begin
                    state_d = FR_RWAIT;
                    addr_d  = full[IBITS-1:3];
                    load_d  = 1'b1;
                  end
                  OP_WRITE: begin
                    state_d = FR_WDATA;
                    addr_d  = full[IBITS-1:3];
                    load_d  = 1'b1;
                    bidx_d  = '0;
                    got_d   = 1'b0;
                  end
                  OP_WRDS: begin cmd_d.wrds = 1'b1; state_d = FR_DONE; end
                  OP_STO:  begin cmd_d.sto  = 1'b1; state_d = FR_DONE; end
                  OP_ENAS: begin cmd_d.enas = 1'b1; state_d = FR_DONE; end
                  OP_WREN: begin cmd_d.wren = 1'b1; state_d = FR_DONE; end
                  OP_RCL:  begin cmd_d.rcl  = 1'b1; state_d = FR_DONE; end
                  default: state_d = FR_DONE;
                endcase
              end
            end
          end
        end
        FR_WDATA: begin
          if (sck_rise) begin
            wbit   = 1'b1;
            got_d  = 1'b1;
            bidx_d = (bidx_q == BIDX_LAST) ? '0 : bidx_q + 1'b1;
          end
        end
        FR_RWAIT: begin
          if (sck_fall) begin
            state_d = FR_RDATA;
            drive_d = 1'b1;
            bidx_d  = '0;
          end
        end
        FR_RDATA: begin
          if (sck_rise) begin
            if (bidx_q == BIDX_LAST) begin
              drive_d = 1'b0;
              state_d = FR_DONE;
            end else begin
              bidx_d = bidx_q + 1'b1;
            end
          end
        end
        FR_DONE: state_d = FR_DONE;
        default: state_d = FR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      ir_q    <= '0;
      icnt_q  <= '0;
      bidx_q  <= '0;
      got_q   <= 1'b0;
      addr_q  <= '0;
      load_q  <= 1'b0;
      drive_q <= 1'b0;
      we_q    <= 1'b0;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      ir_q    <= ir_d;
      icnt_q  <= icnt_d;
      bidx_q  <= bidx_d;
      got_q   <= got_d;
      addr_q  <= addr_d;
      load_q  <= load_d;
      drive_q <= drive_d;
      we_q    <= we_d;
      cmd_q   <= cmd_d;
    end
  end

  assign addr_o  = addr_q;
  assign load_o  = load_q;
  assign wbit_o  = wbit;
  assign bidx_o  = bidx_q;
  assign drive_o = drive_q;
  assign we_o    = we_q;
  assign cmd_o   = cmd_q;
endmodule

// File: rtl/sshift_word.sv
module sshift_word #(
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic [DATA_W-1:0]         load_data_i,
  input  logic                      wbit_i,
  input  logic [$clog2(DATA_W)-1:0] bidx_i,
  input  logic                      wval_i,
  input  logic                      drive_i,
  output logic [DATA_W-1:0]         word_o,
  output logic                      dout_o,
  output logic                      dout_en_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [DATA_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (load_i)      word_d = load_data_i;
    else if (wbit_i) word_d[bidx_i] = wval_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word_o    = word_q;
  assign dout_o    = drive_i & word_q[bidx_i];
  assign dout_en_o = drive_i;
endmodule

// File: rtl/serial_word_port.sv
module serial_word_port
  import sshift_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              sck_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              dout_en_o,
  input  logic              busy_i,
  input  logic              wr_permit_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic              ram_we_o,
  output logic              cmd_wrds_o,
  output logic              cmd_wren_o,
  output logic              cmd_sto_o,
  output logic              cmd_rcl_o,
  output logic              cmd_enas_o
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int PINS   = 3;
  localparam int P_SEL  = 0;
  localparam int P_SCK  = 1;
  localparam int P_DIN  = 2;
  localparam int BIDX_W = $clog2(DATA_W);

  logic [1:0]        rst_pipe_q;
  logic              rst_core_n;
  logic [PINS-1:0]   pin_raw, pin_s;
  logic              sck_prev_q;
  logic              sck_rise, sck_fall;
  logic              load, wbit, drive;
  logic [BIDX_W-1:0] bidx;
  cmd_t              cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  assign pin_raw[P_SEL] = sel_i;
  assign pin_raw[P_SCK] = sck_i;
  assign pin_raw[P_DIN] = din_i;

  sshift_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i (pin_raw),
    .sync_o  (pin_s)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) sck_prev_q <= 1'b0;
    else             sck_prev_q <= pin_s[P_SCK];
  end
  assign sck_rise =  pin_s[P_SCK] & ~sck_prev_q;
  assign sck_fall = ~pin_s[P_SCK] &  sck_prev_q;

  sshift_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .sel_s       (pin_s[P_SEL]),
    .sck_rise    (sck_rise),
    .sck_fall    (sck_fall),
    .din_s       (pin_s[P_DIN]),
    .busy_i      (busy_i),
    .wr_permit_i (wr_permit_i),
    .addr_o      (ram_addr_o),
    .load_o      (load),
    .wbit_o      (wbit),
    .bidx_o      (bidx),
    .drive_o     (drive),
    .we_o        (ram_we_o),
    .cmd_o       (cmd)
  );

  sshift_word #(.DATA_W(DATA_W)) u_word (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .load_i      (load),
    .load_data_i (ram_rdata_i),
    .wbit_i      (wbit),
    .bidx_i      (bidx),
    .wval_i      (pin_s[P_DIN]),
    .drive_i     (drive),
    .word_o      (ram_wdata_o),
    .dout_o      (dout_o),
    .dout_en_o   (dout_en_o)
  );

  assign cmd_wrds_o = cmd.wrds;
  assign cmd_wren_o = cmd.wren;
  assign cmd_sto_o  = cmd.sto;
  assign cmd_rcl_o  = cmd.rcl;
  assign cmd_enas_o = cmd.enas;
endmodule

// File: rtl/serial_word_port_chk.sv
module serial_word_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_i,
  input logic       wr_permit_i,
  input logic       ram_we_o,
  input logic       dout_o,
  input logic       dout_en_o,
  input logic [4:0] cmd_v,
  input logic       sck_rise
);
  timeunit 1ns;
  timeprecision 100ps;

  AST_WE_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> $past(wr_permit_i)); // R9

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_v, ram_we_o})); // R3

  AST_CMD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_v) |=> !(|cmd_v)); // R3

  AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_v) |-> !$past(busy_i)); // R10

  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en_o |-> !dout_o); // R5

  AST_WE_NOT_READING: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> !dout_en_o); // R6

  AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en_o && $past(dout_en_o) && !$past(sck_rise)) |-> $stable(dout_o)); // R12
endmodule

bind serial_word_port serial_word_port_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_i      (busy_i),
  .wr_permit_i (wr_permit_i),
  .ram_we_o    (ram_we_o),
  .dout_o      (dout_o),
  .dout_en_o   (dout_en_o),
  .cmd_v       ({cmd_wrds_o, cmd_wren_o, cmd_sto_o, cmd_rcl_o, cmd_enas_o}),
  .sck_rise    (sck_rise)
);

// File: tb/serial_word_port_tb.sv
module serial_word_port_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n, sel, sck, din, busy, permit;
  logic        dout, dout_en, ram_we;
  logic [3:0]  ram_addr;
  logic [15:0] ram_wdata, ram_rdata;
  logic        c_wrds, c_wren, c_sto, c_rcl, c_enas;

  logic [15:0] mem [16];
  logic [15:0] exp_mem [16];
  logic        poke_en;
  logic [3:0]  poke_a;
  logic [15:0] poke_d;

  int checks = 0, errors = 0;
  bit done = 0;
  int we_cnt, en_cyc, stray_cyc;
  int cmd_cnt [5];
  logic smp_d, smp_en;

  always #2.5 clk = ~clk;

  serial_word_port u_dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sck_i(sck), .din_i(din),
    .dout_o(dout), .dout_en_o(dout_en), .busy_i(busy), .wr_permit_i(permit),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
    .ram_we_o(ram_we), .cmd_wrds_o(c_wrds), .cmd_wren_o(c_wren),
    .cmd_sto_o(c_sto), .cmd_rcl_o(c_rcl), .cmd_enas_o(c_enas)
  );

  always_ff @(posedge clk) begin
    if (ram_we)       mem[ram_addr] <= ram_wdata;
    else if (poke_en) mem[poke_a]   <= poke_d;
  end
  assign ram_rdata = mem[ram_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_cnt <= 0; en_cyc <= 0; stray_cyc <= 0;
      for (int k = 0; k < 5; k++) cmd_cnt[k] <= 0;
    end else begin
      if (ram_we) we_cnt <= we_cnt + 1;
      if (dout_en) en_cyc <= en_cyc + 1;
      if (!dout_en && dout) stray_cyc <= stray_cyc + 1;
      if (c_wrds) cmd_cnt[0] <= cmd_cnt[0] + 1;
      if (c_sto)  cmd_cnt[1] <= cmd_cnt[1] + 1;
      if (c_enas) cmd_cnt[2] <= cmd_cnt[2] + 1;
      if (c_wren) cmd_cnt[3] <= cmd_cnt[3] + 1;
      if (c_rcl)  cmd_cnt[4] <= cmd_cnt[4] + 1;
    end
  end

  function automatic logic [15:0] init_val(input int a);
    return 16'(a * 16'h0101) ^ 16'h5A00;
  endfunction

  function automatic logic [15:0] wr_val(input int a);
    return 16'(a * 16'h1D3B) ^ 16'hC35A;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic poke(input int a, input logic [15:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_a = 4'(a); poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic sk(input logic d);
    din = d;
    repeat (8) @(posedge clk);
    @(negedge clk);
    smp_d = dout; smp_en = dout_en;
    sck = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic sel_on();
    @(negedge clk);
    sel = 1'b1; sck = 1'b0; din = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sel_off();
    @(negedge clk);
    sel = 1'b0; din = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic send_ins(input logic [7:0] ins, output bit quiet);
    quiet = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sk(ins[i]);
      if (smp_en) quiet = 1'b0;
    end
  endtask

  task automatic do_write(input int a, input logic [31:0] stream, input int nbits, input int lead, input int pause_at);
    bit q;
    sel_on();
    for (int i = 0; i < lead; i++) sk(1'b0);
    send_ins({1'b1, 4'(a), 3'b011}, q);
    for (int i = 0; i < nbits; i++) begin
      sk(stream[i]);
      if (i == pause_at) repeat (300) @(negedge clk);
    end
    sel_off();
  endtask

  task automatic do_read(input int a, input int lead, input logic b0, input bit poke_mid, input int pause_at,
                         output logic [15:0] got, output bit en_ok, output bit tail_off,
                         output bit quiet, output bit hold_ok);
    logic h0;
    en_ok = 1'b1; hold_ok = 1'b1; got = '0;
    sel_on();
    for (int i = 0; i < lead; i++) sk(1'b0);
    send_ins({1'b1, 4'(a), 2'b11, b0}, quiet);
    if (poke_mid) poke(a, ~exp_mem[a]);
    for (int i = 0; i < 16; i++) begin
      sk(1'b0);
      got[i] = smp_d;
      if (!smp_en) en_ok = 1'b0;
      if (i == pause_at) begin
        @(negedge clk); h0 = dout;
        repeat (300) @(negedge clk);
        if (dout !== h0 || !dout_en) hold_ok = 1'b0;
      end
    end
    sk(1'b0);
    tail_off = !smp_en;
    sel_off();
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [3:0] dc);
    bit q;
    sel_on();
    sk(1'b0);
    send_ins({1'b1, dc, op}, q);
    sel_off();
  endtask

  function automatic int op_slot(input logic [2:0] op);
    case (op)
      3'b000: return 0;
      3'b001: return 1;
      3'b010: return 2;
      3'b100: return 3;
      default: return 4;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] got, expw, old;
    bit en_ok, tail_off, quiet, hold_ok;
    int base_we, base_en, pre_cnt [5];
    logic [2:0] ops [5];
    logic [31:0] stream;

    rst_n = 1'b0; sel = 1'b0; sck = 1'b0; din = 1'b0; busy = 1'b0; permit = 1'b1;
    poke_en = 1'b0; poke_a = '0; poke_d = '0;
    repeat (5) @(negedge clk);
    // R5: outputs quiet in reset
    check(!dout_en && !dout && !ram_we && !(c_wrds|c_wren|c_sto|c_rcl|c_enas), "R5 reset",
          {dout_en, dout, ram_we}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int a = 0; a < 16; a++) begin
      poke(a, init_val(a));
      exp_mem[a] = init_val(a);
    end

    // R1 R2 R4 R5: read sweep over every address, varying lead zeros and the ignored bit
    for (int a = 0; a < 16; a++) begin
      do_read(a, a % 4, a[0], 1'b0, -1, got, en_ok, tail_off, quiet, hold_ok);
      check(got === exp_mem[a], "R2 R1 read word", got, exp_mem[a]);
      check(en_ok && tail_off, "R4 enable window", {en_ok, tail_off}, 2'b11);
      check(quiet, "R5 no drive during instruction", quiet, 1);
    end
    check(stray_cyc == 0, "R5 dout without enable", stray_cyc, 0);

    // R6: full writes to every address, then read back
    base_en = en_cyc;
    for (int a = 0; a < 16; a++) begin
      base_we = we_cnt;
      do_write(a, {16'h0, wr_val(a)}, 16, (a + 1) % 3, -1);
      exp_mem[a] = wr_val(a);
      check(we_cnt - base_we == 1, "R6 one write pulse", we_cnt - base_we, 1);
    end
    check(en_cyc == base_en, "R5 no drive during writes", en_cyc - base_en, 0);
    for (int a = 0; a < 16; a++) begin
      do_read(a, 1, 1'b1, 1'b0, -1, got, en_ok, tail_off, quiet, hold_ok);
      check(got === exp_mem[a], "R6 write readback", got, exp_mem[a]);
    end

    // R3 R2: control opcodes with both don't-care patterns
    ops[0] = 3'b000; ops[1] = 3'b001; ops[2] = 3'b010; ops[3] = 3'b100; ops[4] = 3'b101;
    for (int i = 0; i < 10; i++) begin
      for (int k = 0; k < 5; k++) pre_cnt[k] = cmd_cnt[k];
      base_we = we_cnt; base_en = en_cyc;
      do_cmd(ops[i % 5], (i < 5) ? 4'h0 : 4'hF);
      for (int k = 0; k < 5; k++)
        check(cmd_cnt[k] - pre_cnt[k] == ((k == op_slot(ops[i % 5])) ? 1 : 0), "R3 command pulse",
              cmd_cnt[k] - pre_cnt[k], (k == op_slot(ops[i % 5])) ? 1 : 0);
      check(we_cnt == base_we && en_cyc == base_en, "R3 no data side effect", we_cnt - base_we, 0);
    end

    // R7: partial writes keep untouched bits
    for (int n = 1; n <= 12; n += 11) begin end
    begin
      int lens [3];
      lens[0] = 1; lens[1] = 5; lens[2] = 12;
      for (int j = 0; j < 3; j++) begin
        int a;
        logic [15:0] w, mask;
        a = 3 + j;
        w = 16'hB6E9 ^ 16'(j * 16'h3131);
        mask = 16'((32'd1 << lens[j]) - 1);
        base_we = we_cnt;
        do_write(a, {16'h0, w}, lens[j], 0, -1);
        exp_mem[a] = (exp_mem[a] & ~mask) | (w & mask);
        check(we_cnt - base_we == 1, "R7 partial commit pulse", we_cnt - base_we, 1);
        do_read(a, 0, 1'b0, 1'b0, -1, got, en_ok, tail_off, quiet, hold_ok);
        check(got === exp_mem[a], "R7 partial word", got, exp_mem[a]);
      end
    end

    // R6: no data bits means no write
    base_we = we_cnt;
    do_write(7, 32'h0, 0, 0, -1);
    check(we_cnt == base_we, "R6 zero-bit write", we_cnt - base_we, 0);

    // R8: 20 data bits wrap over bits 0..3
    stream = 32'h000A_5C3E;
    do_write(8, stream, 20, 0, -1);
    for (int j = 0; j < 16; j++) expw[j] = (j < 4) ? stream[16 + j] : stream[j];
    exp_mem[8] = expw;
    do_read(8, 0, 1'b0, 1'b0, -1, got, en_ok, tail_off, quiet, hold_ok);
    check(got === exp_mem[8], "R8 wrap overwrite", got, exp_mem[8]);

    // R9: permit low blocks commit
    @(negedge clk) permit = 1'b0;
    base_we = we_cnt;
    do_write(6, 32'h0000_1234, 16, 0, -1);
    check(we_cnt == base_we, "R9 write blocked", we_cnt - base_we, 0);
    @(negedge clk) permit = 1'b1;
    do_read(6, 0, 1'b0, 1'b0, -1, got, en_ok, tail_off, quiet, hold_ok);
    check(got === exp_mem[6], "R9 word unchanged", got, exp_mem[6]);

    // R10: busy blocks every instruction kind
    @(negedge clk) busy = 1'b1;
    for (int k = 0; k < 5; k++) pre_cnt[k] = cmd_cnt[k];
    base_we = we_cnt; base_en = en_cyc;
    do_cmd(3'b001, 4'h0);
    do_write(9, 32'h0000_FFFF, 16, 0, -1);
    do_read(9, 0, 1'b0, 1'b0, -1, got, en_ok, tail_off, quiet, hold_ok);
    check(cmd_cnt[1] == pre_cnt[1], "R10 store ignored", cmd_cnt[1] - pre_cnt[1], 0);
    check(we_cnt == base_we, "R10 write ignored", we_cnt - base_we, 0);
    check(en_cyc == base_en, "R10 read ignored", en_cyc - base_en, 0);
    @(negedge clk) busy = 1'b0;

    // R11: aborted instruction and aborted read
    sel_on(); sk(1'b1); sk(1'b0); sk(1'b1); sel_off();
    for (int k = 0; k < 5; k++) pre_cnt[k] = cmd_cnt[k];
    do_cmd(3'b100, 4'h5);
    check(cmd_cnt[3] - pre_cnt[3] == 1 && cmd_cnt[0] == pre_cnt[0] && cmd_cnt[1] == pre_cnt[1],
          "R11 fresh frame after abort", cmd_cnt[3] - pre_cnt[3], 1);
    sel_on(); sk(1'b0);
    send_ins({1'b1, 4'd10, 3'b110}, quiet);
    for (int i = 0; i < 5; i++) sk(1'b0);
    sel_off();
    check(!dout_en, "R11 drive dropped on deselect", dout_en, 0);
    do_read(10, 2, 1'b0, 1'b0, -1, got, en_ok, tail_off, quiet, hold_ok);
    check(got === exp_mem[10], "R11 read after abort", got, exp_mem[10]);

    // R12: stopped clock during write and during read
    do_write(11, {16'h0, 16'h9C71}, 16, 0, 7);
    exp_mem[11] = 16'h9C71;
    do_read(11, 0, 1'b1, 1'b0, 4, got, en_ok, tail_off, quiet, hold_ok);
    check(got === exp_mem[11], "R12 write across pause", got, exp_mem[11]);
    check(hold_ok, "R12 output held while stopped", hold_ok, 1);

    // R13: RAM word changed after decode does not alter shifted word
    old = exp_mem[12];
    do_read(12, 0, 1'b0, 1'b1, -1, got, en_ok, tail_off, quiet, hold_ok);
    check(got === old, "R13 word latched at decode", got, old);
    exp_mem[12] = ~old;
    do_read(12, 0, 1'b0, 1'b0, -1, got, en_ok, tail_off, quiet, hold_ok);
    check(got === exp_mem[12], "R13 next read sees new word", got, exp_mem[12]);

    check(stray_cyc == 0, "R5 dout without enable overall", stray_cyc, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule